// File: doc/BRIEF.md
# Size-Selectable Integer ALU

This block performs logic, negate, compare and extension operations on a 32-bit destination operand, with an operand size field that narrows each operation to byte, word or longword. The caller supplies the destination register value, a source value (already chosen between a register and an immediate), an opcode, a size and the current condition flags. The block returns the result, a write-back enable, an illegal-operation indication and updated N, Z, V, C flags.

The computation itself is combinational; the result is captured in a single output register behind a valid/ready handshake. An operation is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer (`out_ready` low while `out_valid` is high) stops new operations from being accepted and freezes every output field until the consumer takes it. There is no internal queue; a full back-to-back rate needs `out_ready` held high.

Top module: `szalu_top`

## Requirements
- R1: Opcodes AND (0), OR (1) and XOR (2) combine `in_dst` with `in_src` bitwise over the selected size; size codes are byte 0 (bits 7:0), word 1 (bits 15:0), longword 2 (bits 31:0). Result bits above the selected size equal `in_dst`.
- R2: Opcode NOT (3) returns the one's complement of `in_dst` over the selected size, with the bits above passed through from `in_dst`.
- R3: Opcode NEG (4) returns zero minus `in_dst` over the selected size; V is set when the operand is the most negative value of that size, and C (borrow) is set when the operand is non-zero at that size.
- R4: Opcode CMP (5) forms `in_dst - in_src` at the selected size only for the flags: N and Z from the difference, V on signed overflow, C on unsigned borrow. `out_wen` is 0 and `out_result` equals `in_dst`.
- R5: Opcode EXTU (6) at word size clears bits 15:8 and keeps 7:0; at longword size clears bits 31:16 and keeps 15:0. Bits above a word result pass through from `in_dst`.
- R6: Opcode EXTS (7) at word size copies bit 7 into bits 15:8; at longword size copies bit 15 into bits 31:16.
- R7: Flags are packed as bit 3 N, bit 2 Z, bit 1 V, bit 0 C. N is the top bit of the selected size of the result (of the difference for CMP) and Z is set when all bits of that size are zero.
- R8: Logic and extension opcodes (0,1,2,3,6,7) clear V and copy C from `in_flags[0]`.
- R9: An extension opcode at byte size, or any opcode with size code 3, is illegal: `out_illegal` is 1, `out_wen` is 0, `out_flags` equals `in_flags` and `out_result` equals `in_dst`. Every legal opcode other than CMP sets `out_wen` to 1.
- R10: An accepted operation appears on the outputs with `out_valid` high on the next clock edge. While `out_valid` is high and `out_ready` is low, `in_ready` is low and all output fields hold their values.
- R11: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 3 | Opcode |
| in_size | input | 2 | Operand size code |
| in_dst | input | 32 | Destination operand |
| in_src | input | 32 | Source register value or immediate |
| in_flags | input | 4 | Current flags {N,Z,V,C} |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Result value |
| out_wen | output | 1 | Result is to be written back |
| out_illegal | output | 1 | Opcode/size pair is not allowed |
| out_flags | output | 4 | New flags {N,Z,V,C} |

## Verification
The hardest cases to reach from the ports are the signed-overflow corners of NEG and CMP, which need the most negative value of exactly the selected size while the bits above it carry unrelated data; uniform random operands almost never produce them. The stimulus therefore plants boundary values (0, the top bit alone, all ones) into the low lane of otherwise random words for a share of the random operations, alongside directed cases for each size. Back-pressure is exercised by holding `out_ready` low for a random number of cycles after some operations and checking that the held outputs do not move.

// File: rtl/szalu_pkg.sv
package szalu_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_NOT  = 3'd3,
    OP_NEG  = 3'd4,
    OP_CMP  = 3'd5,
    OP_EXTU = 3'd6,
    OP_EXTS = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } alu_size_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;

  localparam int unsigned NUM_LANES = 3;

endpackage

// File: rtl/szalu_sub.sv
module szalu_sub
  import szalu_pkg::*;
#(
  parameter int unsigned LANE0_W = 8,
  localparam int unsigned W = LANE0_W << (NUM_LANES - 1)
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  input  logic [1:0]   size,
  output logic [W-1:0] diff,
  output logic         borrow,
  output logic         ovf
);

  logic [W-1:0]         lane_diff [NUM_LANES];
  logic [NUM_LANES-1:0] lane_borrow;
  logic [NUM_LANES-1:0] lane_ovf;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int unsigned LW = LANE0_W << i;
    logic [LW:0] wide;
    assign wide = {1'b0, minuend[LW-1:0]} - {1'b0, subtrahend[LW-1:0]};
    assign lane_borrow[i] = wide[LW];
    assign lane_ovf[i] = (minuend[LW-1] ^ subtrahend[LW-1]) & (wide[LW-1] ^ minuend[LW-1]);
    if (LW < W) begin : g_pad
      assign lane_diff[i] = {{(W-LW){1'b0}}, wide[LW-1:0]};
    end else begin : g_full
      assign lane_diff[i] = wide[LW-1:0];
    end
  end

  always_comb begin
    unique case (size)
      2'd0:    begin diff = lane_diff[0]; borrow = lane_borrow[0]; ovf = lane_ovf[0]; end
      2'd1:    begin diff = lane_diff[1]; borrow = lane_borrow[1]; ovf = lane_ovf[1]; end
      default: begin diff = lane_diff[2]; borrow = lane_borrow[2]; ovf = lane_ovf[2]; end
    endcase
  end

endmodule

// File: rtl/szalu_logic.sv
module szalu_logic
  import szalu_pkg::*;
#(
  parameter int unsigned LANE0_W = 8,
  localparam int unsigned W = LANE0_W << (NUM_LANES - 1),
  localparam int unsigned HW = W / 2,
  localparam int unsigned QW = W / 4
) (
  input  logic [W-1:0] dst,
  input  logic [W-1:0] src,
  input  logic [2:0]   op,
  input  logic [1:0]   size,
  output logic [W-1:0] raw
);

  logic [W-1:0] ext_word;
  logic [W-1:0] ext_long;
  logic         fill_word;
  logic         fill_long;

  always_comb begin
    fill_word = (alu_op_e'(op) == OP_EXTS) ? dst[QW-1] : 1'b0;
    fill_long = (alu_op_e'(op) == OP_EXTS) ? dst[HW-1] : 1'b0;
    ext_word  = {{(W-QW){fill_word}}, dst[QW-1:0]};
    ext_long  = {{HW{fill_long}}, dst[HW-1:0]};
  end

  always_comb begin
    unique case (alu_op_e'(op))
      OP_AND:  raw = dst & src;
      OP_OR:   raw = dst | src;
      OP_XOR:  raw = dst ^ src;
      OP_NOT:  raw = ~dst;
      OP_EXTU,
      OP_EXTS: raw = (size == 2'd1) ? ext_word : ext_long;
      default: raw = dst;
    endcase
  end

endmodule

// File: rtl/szalu_flags.sv
module szalu_flags
  import szalu_pkg::*;
#(
  parameter int unsigned LANE0_W = 8,
  localparam int unsigned W = LANE0_W << (NUM_LANES - 1)
) (
  input  logic [W-1:0] value,
  input  logic [1:0]   size,
  output logic         neg,
  output logic         zero
);

  logic [NUM_LANES-1:0] lane_neg;
  logic [NUM_LANES-1:0] lane_zero;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int unsigned LW = LANE0_W << i;
    assign lane_neg[i]  = value[LW-1];
    assign lane_zero[i] = ~|value[LW-1:0];
  end

  always_comb begin
    unique case (size)
      2'd0:    begin neg = lane_neg[0]; zero = lane_zero[0]; end
      2'd1:    begin neg = lane_neg[1]; zero = lane_zero[1]; end
      default: begin neg = lane_neg[2]; zero = lane_zero[2]; end
    endcase
  end

endmodule

// File: rtl/szalu_top.sv
module szalu_top
  import szalu_pkg::*;
#(
  parameter int unsigned LANE0_W = 8,
  localparam int unsigned W = LANE0_W << (NUM_LANES - 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [2:0]   in_op,
  input  logic [1:0]   in_size,
  input  logic [W-1:0] in_dst,
  input  logic [W-1:0] in_src,
  input  logic [3:0]   in_flags,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_wen,
  output logic         out_illegal,
  output logic [3:0]   out_flags
);

  alu_op_e      op;
  alu_flags_t   flags_in;
  logic         is_ext;
  logic         is_arith;
  logic         legal;
  logic [W-1:0] size_mask;
  logic [W-1:0] sub_a;
  logic [W-1:0] sub_b;
  logic [W-1:0] sub_diff;
  logic         sub_borrow;
  logic         sub_ovf;
  logic [W-1:0] logic_raw;
  logic [W-1:0] arith_merged;
  logic [W-1:0] logic_merged;
  logic [W-1:0] flag_src;
  logic         f_neg;
  logic         f_zero;
  logic [W-1:0] res_c;
  alu_flags_t   flags_c;
  logic         wen_c;
  logic         accept;

  assign op       = alu_op_e'(in_op);
  assign flags_in = alu_flags_t'(in_flags);
  assign is_ext   = (op == OP_EXTU) || (op == OP_EXTS);
  assign is_arith = (op == OP_NEG) || (op == OP_CMP);
  assign legal    = (alu_size_e'(in_size) != SZ_RSVD) &&
                    !(is_ext && (alu_size_e'(in_size) == SZ_BYTE));

  always_comb begin
    unique case (alu_size_e'(in_size))
      SZ_BYTE: size_mask = {{(W-LANE0_W){1'b0}}, {LANE0_W{1'b1}}};
      SZ_WORD: size_mask = {{(W-2*LANE0_W){1'b0}}, {(2*LANE0_W){1'b1}}};
      default: size_mask = {W{1'b1}};
    endcase
  end

  assign sub_a = (op == OP_NEG) ? '0 : in_dst;
  assign sub_b = (op == OP_NEG) ? in_dst : in_src;

  szalu_sub #(.LANE0_W(LANE0_W)) u_sub (
    .minuend    (sub_a),
    .subtrahend (sub_b),
    .size       (in_size),
    .diff       (sub_diff),
    .borrow     (sub_borrow),
    .ovf        (sub_ovf)
  );

  szalu_logic #(.LANE0_W(LANE0_W)) u_logic (
    .dst  (in_dst),
    .src  (in_src),
    .op   (in_op),
    .size (in_size),
    .raw  (logic_raw)
  );

  assign arith_merged = (sub_diff & size_mask) | (in_dst & ~size_mask);
  assign logic_merged = (logic_raw & size_mask) | (in_dst & ~size_mask);
  assign flag_src     = is_arith ? sub_diff : logic_merged;

  szalu_flags #(.LANE0_W(LANE0_W)) u_flags (
    .value (flag_src),
    .size  (in_size),
    .neg   (f_neg),
    .zero  (f_zero)
  );

  always_comb begin
    res_c   = in_dst;
    flags_c = flags_in;
    wen_c   = 1'b0;
    if (legal) begin
      wen_c     = (op != OP_CMP);
      flags_c.n = f_neg;
      flags_c.z = f_zero;
      if (is_arith) begin
        flags_c.v = sub_ovf;
        flags_c.c = sub_borrow;
        if (op == OP_NEG) res_c = arith_merged;
      end else begin
        flags_c.v = 1'b0;
        res_c     = logic_merged;
      end
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
      out_flags   <= '0;
    end else begin
      if (accept) begin
        out_valid   <= 1'b1;
        out_result  <= res_c;
        out_wen     <= wen_c;
        out_illegal <= !legal;
        out_flags   <= flags_c;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/szalu_chk.sv
module szalu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [2:0]  in_op,
  input logic [1:0]  in_size,
  input logic [3:0]  in_flags,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_result,
  input logic        out_wen,
  input logic        out_illegal,
  input logic [3:0]  out_flags
);

  logic acc;
  assign acc = in_valid && in_ready;

  // R10: a stalled output blocks the input and holds every field
  a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)
                                   && $stable(out_wen) && $stable(out_illegal)));

  a_r10_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R4: compare never requests write-back
  a_r4_cmp_no_wen: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 3'd5) |=> !out_wen);

  // R9: extension at byte size is illegal and keeps flags
  a_r9_ext_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op[2:1] == 2'b11 && in_size == 2'd0) |=>
      (out_illegal && !out_wen && out_flags == $past(in_flags)));

  a_r9_rsvd_size: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_size == 2'd3) |=> (out_illegal && !out_wen));

  // R8: logic ops clear V and keep C
  a_r8_logic_vc: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op[2] == 1'b0 && in_size != 2'd3) |=>
      (!out_flags[1] && out_flags[0] == $past(in_flags[0])));

  // R11: nothing pending right after reset
  a_r11_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));

endmodule

bind szalu_top szalu_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_size     (in_size),
  .in_flags    (in_flags),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_wen     (out_wen),
  .out_illegal (out_illegal),
  .out_flags   (out_flags)
);

// File: tb/tb_szalu_top.sv
`timescale 1ns/1ps
module tb_szalu_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_dst = '0;
  logic [31:0] in_src = '0;
  logic [3:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wen;
  logic        out_illegal;
  logic [3:0]  out_flags;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  szalu_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_dst(in_dst), .in_src(in_src),
    .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_wen(out_wen), .out_illegal(out_illegal),
    .out_flags(out_flags)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns {result[37:6], wen[5], illegal[4], flags[3:0]}
  function automatic logic [37:0] model(input logic [2:0] op, input logic [1:0] sz,
                                        input logic [31:0] d, input logic [31:0] s,
                                        input logic [3:0] f);
    logic [31:0] m, sb, x, r;
    logic n, z, v, c, ill;
    m  = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    sb = (sz == 0) ? 32'h80 : (sz == 1) ? 32'h8000 : 32'h8000_0000;
    ill = (sz == 3) || (op >= 6 && sz == 0);
    if (ill) return {d, 1'b0, 1'b1, f};
    v = 1'b0;
    c = f[0];
    x = d;
    case (op)
      3'd0: x = d & s;
      3'd1: x = d | s;
      3'd2: x = d ^ s;
      3'd3: x = ~d;
      3'd4: begin x = 32'd0 - d; c = (d & m) != 0; v = (d & m) == sb; end
      3'd5: begin
        x = d - s;
        c = (d & m) < (s & m);
        v = ((d & sb) != (s & sb)) && ((x & sb) != (d & sb));
      end
      3'd6: x = (sz == 1) ? (d & 32'hFF) : (d & 32'hFFFF);
      default: x = (sz == 1) ? {{24{d[7]}}, d[7:0]} : {{16{d[15]}}, d[15:0]};
    endcase
    n = (x & sb) != 0;
    z = (x & m) == 0;
    r = (op == 3'd5) ? d : ((x & m) | (d & ~m));
    return {r, op != 3'd5, 1'b0, n, z, v, c};
  endfunction

  function automatic string res_tag(input logic [2:0] op, input logic [1:0] sz);
    if (sz == 3 || (op >= 6 && sz == 0)) return "R9";
    case (op)
      3'd0, 3'd1, 3'd2: return "R1";
      3'd3: return "R2";
      3'd4: return "R3";
      3'd5: return "R4";
      3'd6: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic string flag_tag(input logic [2:0] op, input logic [1:0] sz);
    if (sz == 3 || (op >= 6 && sz == 0)) return "R9";
    if (op == 3'd4) return "R3/R7";
    if (op == 3'd5) return "R4/R7";
    return "R8/R7";
  endfunction

  task automatic send(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] d,
                      input logic [31:0] s, input logic [3:0] f, input int stall);
    logic [37:0] e;
    string rt, ft;
    e  = model(op, sz, d, s, f);
    rt = res_tag(op, sz);
    ft = flag_tag(op, sz);
    @(negedge clk);
    in_op = op; in_size = sz; in_dst = d; in_src = s; in_flags = f;
    in_valid = 1'b1;
    out_ready = (stall == 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 out_valid after accept", 64'(out_valid), 64'd1);
    check({rt, " result"}, 64'(out_result), 64'(e[37:6]));
    check({rt, " wen (R9)"}, 64'(out_wen), 64'(e[5]));
    check({rt, " illegal (R9)"}, 64'(out_illegal), 64'(e[4]));
    check({ft, " flags"}, 64'(out_flags), 64'(e[3:0]));
    for (int k = 0; k < stall; k++) begin
      in_dst = ~d;
      @(negedge clk);
      check("R10 in_ready low while stalled", 64'(in_ready), 64'd0);
      check("R10 result held", 64'(out_result), 64'(e[37:6]));
      check("R10 flags held", 64'(out_flags), 64'(e[3:0]));
    end
    out_ready = 1'b1;
    @(posedge clk);
  endtask

  function automatic logic [31:0] corner(input logic [31:0] base, input logic [1:0] sz,
                                         input int unsigned pick);
    logic [31:0] m, v;
    m = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    case (pick % 4)
      0: v = 32'd0;
      1: v = (sz == 0) ? 32'h80 : (sz == 1) ? 32'h8000 : 32'h8000_0000;
      2: v = 32'hFFFF_FFFF;
      default: v = 32'd1;
    endcase
    return (base & ~m) | (v & m);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd5171);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after reset", 64'(out_valid), 64'd0);
    check("R11 in_ready after reset", 64'(in_ready), 64'd1);

    // directed corners
    send(3'd0, 2'd0, 32'hA5A5_F0F0, 32'h0000_0F3C, 4'b0001, 0);   // R1 byte passthrough
    send(3'd1, 2'd1, 32'h1234_0000, 32'hFFFF_0000, 4'b0000, 0);   // R1 word zero, R7
    send(3'd2, 2'd2, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 4'b0000, 0);   // R1 longword N
    send(3'd3, 2'd0, 32'hCAFE_BEFF, 32'h0, 4'b0010, 0);           // R2, R8 clears V
    send(3'd4, 2'd0, 32'h1111_1180, 32'h0, 4'b0000, 0);           // R3 byte overflow
    send(3'd4, 2'd1, 32'h2222_0000, 32'h0, 4'b0001, 0);           // R3 zero, no borrow
    send(3'd4, 2'd2, 32'h0000_0001, 32'h0, 4'b0000, 0);           // R3 longword
    send(3'd5, 2'd1, 32'h0000_1234, 32'hFFFF_1234, 4'b0000, 0);   // R4 equal at word
    send(3'd5, 2'd0, 32'h0000_0001, 32'h0000_0002, 4'b0000, 0);   // R4 borrow
    send(3'd5, 2'd2, 32'h8000_0000, 32'h0000_0001, 4'b0000, 0);   // R4 overflow
    send(3'd6, 2'd1, 32'hDEAD_BEEF, 32'h0, 4'b0001, 0);           // R5 word
    send(3'd6, 2'd2, 32'hDEAD_BEEF, 32'h0, 4'b0000, 0);           // R5 longword
    send(3'd7, 2'd1, 32'h1234_0080, 32'h0, 4'b0000, 0);           // R6 word negative
    send(3'd7, 2'd2, 32'hFFFF_7FFF, 32'h0, 4'b0001, 0);           // R6 longword positive
    send(3'd6, 2'd0, 32'h0000_00FF, 32'h0, 4'b1011, 0);           // R9 ext at byte
    send(3'd0, 2'd3, 32'h1234_5678, 32'h0, 4'b0110, 0);           // R9 reserved size
    send(3'd4, 2'd0, 32'h0000_0005, 32'h0, 4'b0000, 3);           // R10 stall

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      logic [1:0] sz;
      logic [31:0] d, s;
      int unsigned r;
      op = 3'($urandom);
      r  = $urandom % 16;
      sz = (r == 0) ? 2'd3 : 2'($urandom % 3);
      d  = $urandom;
      s  = $urandom;
      if ($urandom % 3 == 0) d = corner(d, sz, $urandom);
      if ($urandom % 3 == 0) s = corner(s, sz, $urandom);
      send(op, sz, d, s, 4'($urandom), ($urandom % 8 == 0) ? int'($urandom % 4) + 1 : 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule